// File: doc/BRIEF.md
# Bit-Level I2C Master Engine

This block produces the I2C bus waveforms for a controller that sequences transfers one primitive at a time. The controller issues a start condition, a stop condition, a byte write (with the target's acknowledge read back), a byte read (followed by an acknowledge bit sent by the master), or a lone acknowledge-style bit in either direction. The engine drives both bus lines as open-drain enables: asserting an enable pulls the line low, deasserting it lets the pull-up raise the line. The SDA pad level is read back for sampling.

All bus timing comes from one phase unit, a count of system clocks supplied with each command and latched when the command is accepted. Every start or stop is three phases, every bit the master sends is four phases, and every bit it receives is five phases. After each bit the engine leaves SCL low and holds SDA low. Leaving reset, the engine issues two stop conditions back to back. This recovers any target left mid-transfer. Clock stretching, arbitration and target mode are not supported.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is held, `busy` is 1, `done` is 0 and both `scl_oe` and `sda_oe` are 1. After release the engine emits two stop conditions with INIT_UNITS clocks per phase (6*INIT_UNITS clocks). `busy` then falls with no `done` pulse, and both lines are left released.
- R2: A command is accepted on a clock where `cmd_valid` is 1, `busy` is 0 and `cmd_code` is a known code: 0 start, 1 stop, 2 byte write, 3 byte read, 4 send bit, 5 get bit. `busy` is 1 from the next cycle.
- R3: `cmd_valid` is ignored while `busy` is 1, and codes 6 and 7 are ignored at all times. An ignored command changes neither the transfer in flight nor the bus lines, and it raises neither `busy` nor `done`.
- R4: A start takes three phases: both lines released, then SDA low with SCL released, then both low. It ends with both enables at 1.
- R5: A stop takes three phases: both low, then SCL released with SDA low, then both released. It ends with both enables at 0.
- R6: A sent bit takes four phases. SDA carries the bit (a 1 means released) for the first three phases, and SCL is released only in the second. In the fourth phase SDA and SCL are both held low.
- R7: A received bit takes five phases. SDA is released for the first four, SCL is released in the second and third, and SDA is sampled on the last clock of the second phase. The fifth phase holds both lines low.
- R8: A byte write sends `tx_byte` MSB first as eight sent bits, then receives one bit (37 phases). `ack_bit` gets the sampled level, and `nack_err` is 1 exactly when that level is high.
- R9: A byte read receives eight bits MSB first into `rx_byte`, then sends `tx_ack` as a ninth bit (44 phases).
- R10: A send-bit command is one sent bit carrying `tx_ack` (4 phases). A get-bit command is one received bit whose level goes to `ack_bit` (5 phases).
- R11: Each phase lasts `div_units` clocks, latched at acceptance, and a value of 0 acts as 1. `busy` stays high for exactly phases*units cycles, and `done` pulses for one cycle in the first cycle `busy` is low.
- R12: Result outputs change only with `done`. `rx_byte` is updated only by a read. `ack_bit` is updated only by a write or a get-bit. `nack_err` is rewritten at every completion and is 1 only after a write that saw a high acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_units | input | DIV_W | Phase length in clocks, latched at acceptance |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | Command code |
| tx_byte | input | 8 | Byte to send for a write |
| tx_ack | input | 1 | Bit to send after a read, or for send-bit |
| busy | output | 1 | Transfer in progress; new commands are ignored |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte received by the last read |
| ack_bit | output | 1 | Level sampled by the last write acknowledge or get-bit |
| nack_err | output | 1 | Last completed command was a write that saw no acknowledge |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA pad level |

## Verification
Byte write and byte read are driven with all 256 data values. Each write pairs its byte with an acknowledge that alternates between low and high, and each read pairs a complementary pattern with an alternating master bit. Every value must appear MSB first at the rising SCL edges and return intact through `rx_byte`, which separates shift-order and bit-drop faults from acknowledge-routing faults. A sweep of phase units from 0 to 4 shows whether the unit is latched and clamped, since a wrong clamp or a missing reload changes the busy length. Single-bit commands, ignored codes and commands raised mid-transfer each confirm that only the intended outputs move.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] CMD_START    = 3'd0;
    localparam logic [2:0] CMD_STOP     = 3'd1;
    localparam logic [2:0] CMD_WRITE    = 3'd2;
    localparam logic [2:0] CMD_READ     = 3'd3;
    localparam logic [2:0] CMD_SEND_BIT = 3'd4;
    localparam logic [2:0] CMD_GET_BIT  = 3'd5;

    typedef enum logic [2:0] {
        OP_INIT, OP_START, OP_STOP, OP_WRITE, OP_READ, OP_SEND_BIT, OP_GET_BIT
    } op_e;

    typedef enum logic [1:0] {ST_START, ST_STOP, ST_TX, ST_RX} step_e;

    function automatic logic cmd_known(input logic [2:0] code);
        return code <= CMD_GET_BIT;
    endfunction

    function automatic op_e decode_cmd(input logic [2:0] code);
        case (code)
            CMD_START:    return OP_START;
            CMD_STOP:     return OP_STOP;
            CMD_WRITE:    return OP_WRITE;
            CMD_READ:     return OP_READ;
            CMD_SEND_BIT: return OP_SEND_BIT;
            default:      return OP_GET_BIT;
        endcase
    endfunction

    // number of steps (conditions or bits) an operation is made of
    function automatic logic [3:0] step_total(input op_e op);
        case (op)
            OP_INIT:           return 4'd2;
            OP_WRITE, OP_READ: return 4'd9;
            default:           return 4'd1;
        endcase
    endfunction

    function automatic step_e step_kind(input op_e op, input logic [3:0] idx);
        case (op)
            OP_INIT, OP_STOP: return ST_STOP;
            OP_START:         return ST_START;
            OP_WRITE:         return (idx == 4'd8) ? ST_RX : ST_TX;
            OP_READ:          return (idx == 4'd8) ? ST_TX : ST_RX;
            OP_SEND_BIT:      return ST_TX;
            default:          return ST_RX;
        endcase
    endfunction

    function automatic logic [2:0] phase_total(input step_e k);
        case (k)
            ST_TX:   return 3'd4;
            ST_RX:   return 3'd5;
            default: return 3'd3;
        endcase
    endfunction

    // returns {scl_oe, sda_oe} for a phase; bit_v is the level to send
    function automatic logic [1:0] line_drive(input step_e k, input logic [2:0] ph,
                                              input logic bit_v);
        case (k)
            ST_START: begin
                if (ph == 3'd0)      return 2'b00;
                else if (ph == 3'd1) return 2'b01;
                else                 return 2'b11;
            end
            ST_STOP: begin
                if (ph == 3'd0)      return 2'b11;
                else if (ph == 3'd1) return 2'b01;
                else                 return 2'b00;
            end
            ST_TX: begin
                if (ph == 3'd3)      return 2'b11;
                else if (ph == 3'd1) return {1'b0, ~bit_v};
                else                 return {1'b1, ~bit_v};
            end
            default: begin
                if (ph == 3'd1 || ph == 3'd2) return 2'b00;
                else if (ph == 3'd4)          return 2'b11;
                else                          return 2'b10;
            end
        endcase
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int W           = 16,
    parameter int RESET_UNITS = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] units,
    output logic         expire
);
    localparam logic [W-1:0] RST_CNT = W'(RESET_UNITS - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = units - W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    assign expire = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_CNT;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_shift_reg.sv
module i2c_shift_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d = load_val;
        else if (shift)
            sh_d = {sh_q[W-2:0], shift_in};
    end

    assign q = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_bit_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int INIT_UNITS = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_units,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [7:0]       tx_byte,
    input  logic             tx_ack,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_byte,
    output logic             ack_bit,
    output logic             nack_err,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int SH_W = BYTE_W + 1;
    localparam logic [DIV_W-1:0] INIT_U = DIV_W'(INIT_UNITS);

    typedef struct packed {
        op_e              op;
        logic [3:0]       step;
        logic [2:0]       phase;
        logic [DIV_W-1:0] units;
        logic             sample;
        logic             scl_oe;
        logic             sda_oe;
        logic             busy;
        logic             done;
        logic [7:0]       rx_byte;
        logic             ack;
        logic             nack;
    } eng_t;

    eng_t q, d;

    logic             accept, tick, tmr_load;
    logic [DIV_W-1:0] tmr_units, eff_units;
    logic             sh_load, sh_shift, sh_in;
    logic [SH_W-1:0]  sh_q, sh_val;
    op_e              op_new, cur_op;
    step_e            kind_cur, kind_nxt;
    logic [1:0]       lines;
    logic             last_phase, last_step;

    i2c_phase_timer #(.W(DIV_W), .RESET_UNITS(INIT_UNITS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .units  (tmr_units),
        .expire (tick)
    );

    i2c_shift_reg #(.W(SH_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .shift_in (sh_in),
        .q        (sh_q)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        tmr_load   = 1'b0;
        tmr_units  = q.units;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        sh_in      = 1'b0;
        sh_val     = '1;
        lines      = {q.scl_oe, q.sda_oe};
        eff_units  = (div_units == '0) ? DIV_W'(1) : div_units;
        op_new     = decode_cmd(cmd_code);
        accept     = cmd_valid && !q.busy && cmd_known(cmd_code);
        kind_cur   = step_kind(q.op, q.step);
        kind_nxt   = kind_cur;
        last_phase = (q.phase == phase_total(kind_cur) - 3'd1);
        last_step  = (q.step == step_total(q.op) - 4'd1);

        if (accept) begin
            d.op      = op_new;
            d.step    = '0;
            d.phase   = '0;
            d.units   = eff_units;
            d.busy    = 1'b1;
            tmr_load  = 1'b1;
            tmr_units = eff_units;
            sh_load   = 1'b1;
            case (op_new)
                OP_WRITE:    sh_val = {tx_byte, 1'b1};
                OP_READ:     sh_val = {8'hFF, tx_ack};
                OP_SEND_BIT: sh_val = {tx_ack, 8'h00};
                default:     sh_val = '1;
            endcase
            kind_nxt = step_kind(op_new, 4'd0);
            lines    = line_drive(kind_nxt, 3'd0, sh_val[SH_W-1]);
        end else if (q.busy && tick) begin
            if (kind_cur == ST_RX && q.phase == 3'd1)
                d.sample = sda_in;
            if (!last_phase) begin
                d.phase  = q.phase + 3'd1;
                tmr_load = 1'b1;
                lines    = line_drive(kind_cur, q.phase + 3'd1, sh_q[SH_W-1]);
            end else begin
                if (kind_cur == ST_TX || kind_cur == ST_RX) begin
                    sh_shift = 1'b1;
                    sh_in    = (kind_cur == ST_RX) ? q.sample : 1'b0;
                end
                if (!last_step) begin
                    d.step   = q.step + 4'd1;
                    d.phase  = '0;
                    tmr_load = 1'b1;
                    kind_nxt = step_kind(q.op, q.step + 4'd1);
                    lines    = line_drive(kind_nxt, 3'd0,
                                          sh_shift ? sh_q[SH_W-2] : sh_q[SH_W-1]);
                end else begin
                    d.busy = 1'b0;
                    d.done = (q.op != OP_INIT);
                    d.nack = 1'b0;
                    case (q.op)
                        OP_WRITE: begin
                            d.ack  = q.sample;
                            d.nack = q.sample;
                        end
                        OP_READ:    d.rx_byte = sh_q[BYTE_W-1:0];
                        OP_GET_BIT: d.ack = q.sample;
                        default: ;
                    endcase
                end
            end
        end

        d.scl_oe = lines[1];
        d.sda_oe = lines[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.op      <= OP_INIT;
            q.step    <= '0;
            q.phase   <= '0;
            q.units   <= INIT_U;
            q.sample  <= 1'b0;
            q.scl_oe  <= 1'b1;
            q.sda_oe  <= 1'b1;
            q.busy    <= 1'b1;
            q.done    <= 1'b0;
            q.rx_byte <= '0;
            q.ack     <= 1'b0;
            q.nack    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cur_op   = q.op;
    assign busy     = q.busy;
    assign done     = q.done;
    assign rx_byte  = q.rx_byte;
    assign ack_bit  = q.ack;
    assign nack_err = q.nack;
    assign scl_oe   = q.scl_oe;
    assign sda_oe   = q.sda_oe;
endmodule

// File: rtl/i2c_bit_engine_props.sv
module i2c_bit_engine_props
    import i2c_bit_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic [7:0] rx_byte,
    input logic       ack_bit,
    input logic       nack_err,
    input logic       scl_oe,
    input logic       sda_oe,
    input op_e        op
);
    logic bit_ctx;
    assign bit_ctx = busy && (op == OP_WRITE || op == OP_READ ||
                              op == OP_SEND_BIT || op == OP_GET_BIT);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_from_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(cmd_valid));

    assert_results_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rx_byte) && $stable(ack_bit) && $stable(nack_err)));

    assert_sda_steady_high_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ctx && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

    assert_idle_lines_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));
endmodule

bind i2c_bit_engine i2c_bit_engine_props u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .ack_bit   (ack_bit),
    .nack_err  (nack_err),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .op        (cur_op)
);

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
    import i2c_bit_pkg::*;

    localparam int DIV_W  = 16;
    localparam int INIT_U = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_units = '0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_code = '0;
    logic [7:0]       tx_byte = '0;
    logic             tx_ack = 1'b0;
    logic             busy, done, ack_bit, nack_err, scl_oe, sda_oe;
    logic [7:0]       rx_byte;
    logic             sda_line, scl_line, slv_pull;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit wd_hit = 1'b0;

    // bench-side target model: pulls SDA for bit k when resp[8-k] is 0
    logic       slv_en = 1'b0;
    logic [8:0] resp = '1;
    int fall_base = 0;
    int fall_tot = 0, rise_tot = 0, start_tot = 0, stop_tot = 0;
    logic [63:0] bits_log = '0;
    logic p_scl = 1'b0, p_sda = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        int idx;
        idx = fall_tot - fall_base;
        slv_pull = slv_en && idx >= 0 && idx <= 8 && !resp[8 - idx];
    end
    assign sda_line = !(sda_oe || slv_pull);
    assign scl_line = !scl_oe;

    i2c_bit_engine #(.DIV_W(DIV_W), .INIT_UNITS(INIT_U)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_units (div_units),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .tx_byte   (tx_byte),
        .tx_ack    (tx_ack),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte),
        .ack_bit   (ack_bit),
        .nack_err  (nack_err),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .sda_in    (sda_line)
    );

    // bus monitor
    always @(negedge clk) begin
        if (!p_scl && scl_line) begin
            rise_tot <= rise_tot + 1;
            bits_log <= {bits_log[62:0], sda_line};
        end
        if (p_scl && !scl_line) fall_tot <= fall_tot + 1;
        if (p_scl && scl_line && p_sda && !sda_line) start_tot <= start_tot + 1;
        if (p_scl && scl_line && !p_sda && sda_line) stop_tot <= stop_tot + 1;
        p_scl <= scl_line;
        p_sda <= sda_line;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int  base_rise, base_start, base_stop;
    int  n_cyc;
    bit  done_end;

    task automatic run_cmd(input logic [2:0] code, input logic [7:0] tb, input logic ta,
                           input int units, input logic [8:0] rsp, input bit poke);
        base_rise  = rise_tot;
        base_start = start_tot;
        base_stop  = stop_tot;
        fall_base  = fall_tot;
        resp       = rsp;
        slv_en     = 1'b1;
        cmd_code   = code;
        tx_byte    = tb;
        tx_ack     = ta;
        div_units  = DIV_W'(units);
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n_cyc = 0;
        while (busy && !wd_hit) begin
            n_cyc++;
            if (poke && n_cyc == 5) begin
                cmd_valid = 1'b1;
                cmd_code  = CMD_START;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        done_end  = done;
        slv_en    = 1'b0;
    endtask

    function automatic int eff(input int u);
        return (u == 0) ? 1 : u;
    endfunction

    initial begin
        int  rcyc;
        bit  saw_done;
        logic [7:0] rd;
        logic a_r, t_a;
        logic [7:0] prev_rx;
        logic prev_ack;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        chk(scl_oe && sda_oe, "R1 lines held low in reset", {scl_oe, sda_oe}, 3);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        rcyc = 0;
        saw_done = 1'b0;
        while (busy && !wd_hit) begin
            @(negedge clk);
            rcyc++;
            if (done) saw_done = 1'b1;
        end
        chk(rcyc == 6 * INIT_U, "R1 init length", rcyc, 6 * INIT_U);
        chk(stop_tot == 2, "R1 two stops", stop_tot, 2);
        chk(!saw_done && !done, "R1 no done after init", saw_done, 0);
        chk(!scl_oe && !sda_oe, "R1 lines released after init", {scl_oe, sda_oe}, 0);

        // R3: unknown codes at idle
        for (int c = 6; c < 8; c++) begin
            cmd_code  = 3'(c);
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (4) begin
                chk(!busy && !done, "R3 unknown code ignored", {busy, done}, 0);
                chk(!scl_oe && !sda_oe, "R3 lines unchanged", {scl_oe, sda_oe}, 0);
                @(negedge clk);
            end
        end

        // R4 R5 R8 R11: unit sweep with clamp of 0
        for (int u = 0; u < 5; u++) begin
            run_cmd(CMD_START, 8'h00, 1'b0, u, 9'h1FF, 1'b0);
            chk(n_cyc == 3 * eff(u), "R11 start length", n_cyc, 3 * eff(u));
            chk(done_end, "R11 done after start", done_end, 1);
            chk(start_tot - base_start == 1, "R4 start seen", start_tot - base_start, 1);
            chk(scl_oe && sda_oe, "R4 start ends low", {scl_oe, sda_oe}, 3);
            run_cmd(CMD_WRITE, 8'hA5, 1'b0, u, 9'h1FE, 1'b0);
            chk(n_cyc == 37 * eff(u), "R11 write length", n_cyc, 37 * eff(u));
            chk(bits_log[8:0] == 9'h14A, "R8 write bits", bits_log[8:0], 9'h14A);
            run_cmd(CMD_STOP, 8'h00, 1'b0, u, 9'h1FF, 1'b0);
            chk(n_cyc == 3 * eff(u), "R11 stop length", n_cyc, 3 * eff(u));
            chk(stop_tot - base_stop == 1, "R5 stop seen", stop_tot - base_stop, 1);
            chk(!scl_oe && !sda_oe, "R5 stop ends released", {scl_oe, sda_oe}, 0);
        end

        // R3: command raised mid-transfer is ignored
        run_cmd(CMD_START, 8'h00, 1'b0, 1, 9'h1FF, 1'b0);
        run_cmd(CMD_WRITE, 8'h3C, 1'b0, 1, 9'h1FE, 1'b1);
        chk(n_cyc == 37, "R3 busy command ignored length", n_cyc, 37);
        chk(start_tot == base_start, "R3 no extra start", start_tot - base_start, 0);
        chk(bits_log[8:0] == {8'h3C, 1'b0}, "R3 write intact", bits_log[8:0], {8'h3C, 1'b0});

        // R10: single bits
        for (int v = 0; v < 2; v++) begin
            run_cmd(CMD_SEND_BIT, 8'h00, 1'(v), 2, 9'h1FF, 1'b0);
            chk(n_cyc == 8, "R10 send-bit length", n_cyc, 8);
            chk(rise_tot - base_rise == 1 && bits_log[0] == 1'(v), "R10 send-bit level",
                bits_log[0], v);
            chk(scl_oe && sda_oe, "R6 parked low after bit", {scl_oe, sda_oe}, 3);
            run_cmd(CMD_GET_BIT, 8'h00, 1'b0, 2, {1'(v), 8'hFF}, 1'b0);
            chk(n_cyc == 10, "R10 get-bit length", n_cyc, 10);
            chk(ack_bit == 1'(v), "R10 get-bit value", ack_bit, v);
            chk(nack_err == 1'b0, "R12 nack cleared by get-bit", nack_err, 0);
            chk(scl_oe && sda_oe, "R7 parked low after bit", {scl_oe, sda_oe}, 3);
        end
        run_cmd(CMD_STOP, 8'h00, 1'b0, 1, 9'h1FF, 1'b0);

        // R6 R7 R8 R9 R12: exhaustive byte sweep
        prev_rx = rx_byte;
        for (int b = 0; b < 256; b++) begin
            rd  = 8'(b) ^ 8'h3C;
            a_r = 1'(b & 1);
            t_a = 1'((b >> 1) & 1);
            run_cmd(CMD_START, 8'h00, 1'b0, 1, 9'h1FF, 1'b0);
            run_cmd(CMD_WRITE, 8'(b), 1'b0, 1, {8'hFF, a_r}, 1'b0);
            chk(n_cyc == 37, "R8 write length", n_cyc, 37);
            chk(bits_log[8:0] == {8'(b), a_r}, "R6 R8 bits on bus", bits_log[8:0], {8'(b), a_r});
            chk(ack_bit == a_r, "R8 ack sampled", ack_bit, a_r);
            chk(nack_err == a_r, "R8 nack flag", nack_err, a_r);
            chk(rx_byte == prev_rx, "R12 write leaves rx_byte", rx_byte, prev_rx);
            prev_ack = ack_bit;
            run_cmd(CMD_READ, 8'h00, t_a, 1, {rd, 1'b1}, 1'b0);
            chk(n_cyc == 44, "R9 read length", n_cyc, 44);
            chk(rx_byte == rd, "R7 R9 read data", rx_byte, rd);
            chk(bits_log[0] == t_a, "R9 master bit after read", bits_log[0], t_a);
            chk(ack_bit == prev_ack, "R12 read leaves ack_bit", ack_bit, prev_ack);
            chk(nack_err == 1'b0, "R12 nack rewritten by read", nack_err, 0);
            prev_rx = rx_byte;
            run_cmd(CMD_STOP, 8'h00, 1'b0, 1, 9'h1FF, 1'b0);
            chk(stop_tot - base_stop == 1, "R5 stop after sweep", stop_tot - base_stop, 1);
        end

        summary();
        $finish;
    end
endmodule